// File: doc/BRIEF.md
# Automatic Boost Enable Controller

This block decides, one clock at a time, whether the boost converter that feeds a Class-D output stage is running or bypassed so that the stage runs straight from the battery. It watches a sampled code for the peak output level and turns the boost on in the clock after that code goes above a threshold that stands for 2 Vpk. It turns the boost off only after the level has stayed at or below the threshold for an unbroken hold window, counted in microsecond ticks (125 ms by default).

Each time the boost starts, the block drives a 12-bit input-current-limit reference in mA. The reference starts from zero and climbs by a fixed step on every microsecond tick. It releases to the steady peak limit once a digitised boost-output code reaches the regulation code. A master enable forces everything off synchronously. The analog converter, the comparators and the current sensing sit outside the block and reach it only as codes.

The controller is a four-state machine with two helper counters: a hold timer and a ramp accumulator. The states are:
- `ST_OFF`: enable low.
- `ST_BYPASS`: enabled, boost off.
- `ST_RAMP`: boost on, limit ramping.
- `ST_REG`: boost on, limit released.

The transitions are:
- `go_off`: any state to `ST_OFF` when enable is low.
- `wake_idle`: `ST_OFF` to `ST_BYPASS` when enable is high and the level is not above the threshold.
- `wake_start`: `ST_OFF` to `ST_RAMP` when enable is high and the level is above the threshold.
- `loud_start`: `ST_BYPASS` to `ST_RAMP` when the level goes above the threshold.
- `release`: `ST_RAMP` to `ST_REG` on a tick with the output at regulation.
- `quiet_drop`: `ST_RAMP` or `ST_REG` to `ST_BYPASS` when the hold window expires.

Top module: `boost_auto_ctrl`

## Requirements
- R1: After reset, `boost_en` is 0 and `ilim_ref` is 0.
- R2: With `en` low at a clock edge, `boost_en` and `ilim_ref` are 0 after that edge whatever the level code is, and the hold count and ramp restart from zero.
- R3: With `en` high, a `level_code` strictly greater than `LVL_THRESH` at a clock edge makes `boost_en` 1 after that edge. A code equal to or below the threshold does not start the boost.
- R4: `boost_en` falls at the first clock edge after `HOLD_US` consecutive ticks have each seen the level not above the threshold. Any cycle with the level above the threshold clears the count, and this takes priority over an expiry pending in the same cycle.
- R5: On entry to the ramp, `ilim_ref` is 0. Each `us_tick` in the ramp adds `RAMP_STEP` to it, saturating at `ILIM_PEAK`.
- R6: In the ramp, a tick with `vout_code >= VREG_CODE` makes `ilim_ref` equal `ILIM_PEAK` from that edge on. This release takes precedence over the step on that tick. Without a tick, a regulated output releases nothing.
- R7: Every start runs the same sequence. The reference begins at 0 and no release happens before the first tick, even when `vout_code` is already at regulation as the start begins.
- R8: Whenever `boost_en` is 0, `ilim_ref` is 0.
- R9: The hold window also runs during the ramp. Its expiry turns the boost off even if regulation was never reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Master enable; low forces the boost off |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| level_code | input | LVL_W | Sampled peak output level code |
| vout_code | input | VOUT_W | Digitised boost output voltage code |
| boost_en | output | 1 | Boost converter run request |
| ilim_ref | output | ILIM_W | Input current limit reference in mA |

## Verification
Two functions share the microsecond tick: the hold timer and the ramp accumulator. The bench holds the level low straight after a start with the boost output kept below regulation, so each tick both advances the ramp and counts toward the hold. It expects the step-by-step ramp values and then a drop to bypass with no release. The bench also makes the level rise in the very cycle in which the hold count has reached its limit. It then judges that the boost stays on and that a fresh full window is needed before it drops.

// File: rtl/boost_auto_pkg.sv
package boost_auto_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_BYPASS = 2'd1,
        ST_RAMP   = 2'd2,
        ST_REG    = 2'd3
    } boost_state_e;

endpackage

// File: rtl/boost_hold_timer.sv
module boost_hold_timer #(
    parameter int HOLD_US = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic done
);
    localparam int CNT_W = $clog2(HOLD_US + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_US);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == LIMIT);
endmodule

// File: rtl/boost_ilim_ramp.sv
module boost_ilim_ramp #(
    parameter int ILIM_W    = 12,
    parameter int RAMP_STEP = 15,
    parameter int ILIM_PEAK = 1600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    output logic [ILIM_W-1:0] val
);
    localparam logic [ILIM_W:0] STEP_C = (ILIM_W+1)'(RAMP_STEP);
    localparam logic [ILIM_W:0] PEAK_C = (ILIM_W+1)'(ILIM_PEAK);

    logic [ILIM_W-1:0] val_q;
    logic [ILIM_W:0]   sum;

    always_comb begin
        sum = {1'b0, val_q} + STEP_C;
        if (sum > PEAK_C) begin
            sum = PEAK_C;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (!run) begin
            val_q <= '0;
        end else if (tick) begin
            val_q <= sum[ILIM_W-1:0];
        end
    end

    assign val = val_q;
endmodule

// File: rtl/boost_mode_fsm.sv
module boost_mode_fsm
    import boost_auto_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         above,
    input  logic         tick,
    input  logic         vout_ok,
    input  logic         hold_done,
    output boost_state_e state,
    output logic         boost_on,
    output logic         ramp_run
);
    boost_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:    state_d = above ? ST_RAMP : ST_BYPASS;
                ST_BYPASS: if (above) state_d = ST_RAMP;
                ST_RAMP: begin
                    if (!above && hold_done)  state_d = ST_BYPASS;
                    else if (tick && vout_ok) state_d = ST_REG;
                end
                ST_REG: if (!above && hold_done) state_d = ST_BYPASS;
                default: state_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        state    = state_q;
        boost_on = 1'b0;
        ramp_run = 1'b0;
        unique case (state_q)
            ST_OFF, ST_BYPASS: ;
            ST_RAMP: begin
                boost_on = 1'b1;
                ramp_run = 1'b1;
            end
            ST_REG:  boost_on = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/boost_auto_ctrl.sv
module boost_auto_ctrl
    import boost_auto_pkg::*;
#(
    parameter int LVL_W      = 8,
    parameter int LVL_THRESH = 100,
    parameter int VOUT_W     = 8,
    parameter int VREG_CODE  = 200,
    parameter int ILIM_W     = 12,
    parameter int RAMP_STEP  = 15,
    parameter int ILIM_PEAK  = 1600,
    parameter int HOLD_US    = 125000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              us_tick,
    input  logic [LVL_W-1:0]  level_code,
    input  logic [VOUT_W-1:0] vout_code,
    output logic              boost_en,
    output logic [ILIM_W-1:0] ilim_ref
);
    localparam logic [LVL_W-1:0]  TH_C   = LVL_W'(LVL_THRESH);
    localparam logic [VOUT_W-1:0] VREG_C = VOUT_W'(VREG_CODE);
    localparam logic [ILIM_W-1:0] PEAK_C = ILIM_W'(ILIM_PEAK);

    logic         above, vout_ok, hold_done, hold_clr;
    logic         boost_on, ramp_run;
    boost_state_e state;
    logic [ILIM_W-1:0] ramp_val;

    assign above    = level_code > TH_C;
    assign vout_ok  = vout_code >= VREG_C;
    assign hold_clr = !en || !boost_on || above;

    boost_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .above     (above),
        .tick      (us_tick),
        .vout_ok   (vout_ok),
        .hold_done (hold_done),
        .state     (state),
        .boost_on  (boost_on),
        .ramp_run  (ramp_run)
    );

    boost_hold_timer #(.HOLD_US(HOLD_US)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (hold_clr),
        .tick  (us_tick),
        .done  (hold_done)
    );

    boost_ilim_ramp #(
        .ILIM_W    (ILIM_W),
        .RAMP_STEP (RAMP_STEP),
        .ILIM_PEAK (ILIM_PEAK)
    ) u_ramp (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ramp_run && en),
        .tick  (us_tick),
        .val   (ramp_val)
    );

    always_comb begin
        unique case (state)
            ST_RAMP: ilim_ref = ramp_val;
            ST_REG:  ilim_ref = PEAK_C;
            default: ilim_ref = '0;
        endcase
    end

    assign boost_en = boost_on;
endmodule

// File: rtl/boost_auto_chk.sv
module boost_auto_chk #(
    parameter int LVL_W      = 8,
    parameter int LVL_THRESH = 100,
    parameter int VOUT_W     = 8,
    parameter int ILIM_W     = 12,
    parameter int RAMP_STEP  = 15,
    parameter int ILIM_PEAK  = 1600
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [LVL_W-1:0]  level_code,
    input logic              boost_en,
    input logic [ILIM_W-1:0] ilim_ref
);
    localparam logic [LVL_W-1:0]  TH_C   = LVL_W'(LVL_THRESH);
    localparam logic [ILIM_W-1:0] PEAK_C = ILIM_W'(ILIM_PEAK);
    localparam logic [ILIM_W-1:0] STEP_C = ILIM_W'(RAMP_STEP);

    // R2
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !boost_en);

    // R3
    loud_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (level_code > TH_C)) |=> boost_en);

    // R8
    idle_ilim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boost_en |-> (ilim_ref == '0));

    // R5
    ilim_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ilim_ref <= PEAK_C);

    // R7
    start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boost_en) |-> (ilim_ref == '0));

    // R5
    ramp_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boost_en && $past(boost_en)) |-> (ilim_ref >= $past(ilim_ref)));

    // R5
    ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boost_en && $past(boost_en) && (ilim_ref != PEAK_C))
            |-> ((ilim_ref - $past(ilim_ref)) <= STEP_C));

    // R4
    quiet_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && $fell(boost_en)) |-> ($past(level_code) <= TH_C));
endmodule

bind boost_auto_ctrl boost_auto_chk #(
    .LVL_W      (LVL_W),
    .LVL_THRESH (LVL_THRESH),
    .VOUT_W     (VOUT_W),
    .ILIM_W     (ILIM_W),
    .RAMP_STEP  (RAMP_STEP),
    .ILIM_PEAK  (ILIM_PEAK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .level_code (level_code),
    .boost_en   (boost_en),
    .ilim_ref   (ilim_ref)
);

// File: tb/tb_boost_auto_ctrl.sv
`timescale 1ns/1ps
module tb_boost_auto_ctrl;
    localparam int LW   = 6;
    localparam int TH   = 20;
    localparam int VW   = 6;
    localparam int VREG = 50;
    localparam int IW   = 12;
    localparam int STEP = 15;
    localparam int PEAK = 100;
    localparam int HOLD = 8;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          en = 0;
    logic          us_tick = 0;
    logic [LW-1:0] level_code = '0;
    logic [VW-1:0] vout_code = '0;
    logic          boost_en;
    logic [IW-1:0] ilim_ref;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    boost_auto_ctrl #(
        .LVL_W(LW), .LVL_THRESH(TH), .VOUT_W(VW), .VREG_CODE(VREG),
        .ILIM_W(IW), .RAMP_STEP(STEP), .ILIM_PEAK(PEAK), .HOLD_US(HOLD)
    ) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .us_tick(us_tick),
        .level_code(level_code), .vout_code(vout_code),
        .boost_en(boost_en), .ilim_ref(ilim_ref)
    );

    task automatic clk1(input bit t);
        us_tick = t;
        @(posedge clk);
        @(negedge clk);
        us_tick = 1'b0;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ramp_exp(input int k);
        return (k * STEP > PEAK) ? PEAK : k * STEP;
    endfunction

    task automatic start_loud();
        en = 1'b0;
        clk1(1'b0);
        en = 1'b1;
        level_code = LW'(TH + 10);
        clk1(1'b0);
    endtask

    task automatic start_reg();
        start_loud();
        vout_code = VW'(63);
        clk1(1'b1);
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) clk1(1'b0);
        rst_n = 1'b1;
        clk1(1'b0);
        chk("R1 boost_en", boost_en, 0);
        chk("R1 ilim", ilim_ref, 0);

        en = 1'b1;
        level_code = LW'(5);
        repeat (12) clk1(1'b1);
        chk("R3 quiet stays bypass", boost_en, 0);
        chk("R8 bypass ilim", ilim_ref, 0);

        for (int l = 0; l < 64; l++) begin
            level_code = LW'(l);
            clk1(1'b0);
            chk("R3 threshold sweep", boost_en, (l > TH) ? 1 : 0);
            chk("R5 entry ilim", ilim_ref, 0);
            level_code = '0;
            en = 1'b0;
            clk1(1'b0);
            chk("R2 en low off", boost_en, 0);
            en = 1'b1;
            clk1(1'b0);
        end

        vout_code = '0;
        start_loud();
        for (int k = 1; k <= 9; k++) begin
            clk1(1'b1);
            chk("R5 ramp step", ilim_ref, ramp_exp(k));
        end

        for (int k = 0; k <= 8; k++) begin
            vout_code = '0;
            start_loud();
            for (int j = 0; j < k; j++) clk1(1'b1);
            vout_code = VW'(VREG - 1);
            clk1(1'b0);
            chk("R6 no release without tick", ilim_ref, ramp_exp(k));
            clk1(1'b1);
            chk("R6 below regulation keeps ramp", ilim_ref, ramp_exp(k + 1));
            vout_code = VW'(VREG);
            clk1(1'b0);
            chk("R6 release waits for tick", ilim_ref, ramp_exp(k + 1));
            clk1(1'b1);
            chk("R6 release to peak", ilim_ref, PEAK);
        end

        for (int r = 0; r < 2; r++) begin
            vout_code = VW'(63);
            start_loud();
            chk("R7 leftover start on", boost_en, 1);
            chk("R7 leftover start zero", ilim_ref, 0);
            clk1(1'b0);
            chk("R7 no early release", ilim_ref, 0);
            clk1(1'b1);
            chk("R7 release on first tick", ilim_ref, PEAK);
        end

        start_reg();
        level_code = LW'(TH);
        for (int j = 1; j <= HOLD; j++) begin
            clk1(1'b1);
            chk("R4 hold keeps boost", boost_en, 1);
        end
        clk1(1'b0);
        chk("R4 hold expiry drops boost", boost_en, 0);
        chk("R8 ilim after drop", ilim_ref, 0);

        for (int j = 1; j < HOLD; j++) begin
            start_reg();
            level_code = LW'(TH);
            for (int i = 0; i < j; i++) clk1(1'b1);
            level_code = LW'(TH + 1);
            clk1(1'b0);
            level_code = LW'(TH);
            for (int i = 1; i < HOLD; i++) clk1(1'b1);
            clk1(1'b0);
            chk("R4 break restarts hold", boost_en, 1);
            clk1(1'b1);
            clk1(1'b0);
            chk("R4 full window after break", boost_en, 0);
        end

        start_reg();
        level_code = LW'(TH);
        for (int i = 0; i < HOLD; i++) clk1(1'b1);
        level_code = LW'(TH + 1);
        clk1(1'b0);
        chk("R4 rise on expiry keeps boost", boost_en, 1);
        level_code = LW'(TH);
        for (int i = 1; i < HOLD; i++) clk1(1'b1);
        clk1(1'b0);
        chk("R4 count cleared by rise", boost_en, 1);
        chk("R6 still at peak", ilim_ref, PEAK);

        vout_code = '0;
        start_loud();
        level_code = '0;
        for (int j = 1; j <= HOLD; j++) begin
            clk1(1'b1);
            chk("R9 ramp while holding", ilim_ref, ramp_exp(j));
            chk("R9 boost on in window", boost_en, 1);
        end
        clk1(1'b0);
        chk("R9 drop without release", boost_en, 0);
        chk("R9 ilim zero", ilim_ref, 0);

        start_reg();
        en = 1'b0;
        clk1(1'b0);
        chk("R2 en low drops boost", boost_en, 0);
        chk("R2 en low ilim", ilim_ref, 0);
        repeat (5) clk1(1'b1);
        chk("R2 loud ignored when off", boost_en, 0);
        vout_code = '0;
        en = 1'b1;
        clk1(1'b0);
        chk("R2 restart on", boost_en, 1);
        chk("R2 restart ramp zero", ilim_ref, 0);
        clk1(1'b1);
        chk("R2 restart first step", ilim_ref, STEP);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule